// File: doc/BRIEF.md
# Alert classifier and cause logger

This block sits in front of a chip's escalation machinery and sorts incoming alert pulses into a small number of classes. It watches a parameterised set of external alert lines plus seven fixed local alert sources that come from the alert infrastructure itself. Each source has an enable bit and a class field. When an enabled source fires, the block does three things. It latches a sticky cause bit for that source. It emits a one-cycle hit pulse for the assigned class. It sets the interrupt state bit of that class.

Configuration comes in through a simple write port made of an operation select, an item index and a data byte. Each source also has a lock bit. The lock resets to one and can only be cleared, and once it is clear the enable and class fields of that source are frozen until reset. Software clears cause bits and interrupt state bits by writing one to them. If the hardware sets a bit in the same cycle that software clears it, the set wins, so no event is lost.

The enable, class and lock state is driven out on ports so that downstream ping and escalation logic can use it.

Top module: `alert_cls_top`

## Requirements
- R1: Out of reset every lock bit is 1, every enable is 0, every class field is 0, and all cause bits, interrupt state bits and class hits are 0.
- R2: A write with select 0 and data bit 0 equal to 0 clears the lock of the addressed source. Writing 1 to a lock has no effect. A cleared lock stays cleared until reset.
- R3: While a source's lock is 0, writes to its enable (select 1, data bit 0) and to its class (select 2) are ignored, and the enableOut and classMapOut ports keep their values.
- R4: External alert i has index i. Local alert k has index NumAlerts+k, where k is 0 alert ping failure, 1 escalation ping failure, 2 alert integrity failure, 3 escalation integrity failure, 4 bus integrity failure, 5 shadow update error and 6 shadow storage error. Writes with a select above 4, or with an index outside the valid range for that operation, change nothing.
- R5: When an enabled source fires, its causeOut bit is 1 from the next clock on. The bit stays set until a write with select 3, the source's index and data bit 0 equal to 1. The same write with data bit 0 equal to 0 has no effect.
- R6: A source whose enable is 0 sets no cause bit, produces no class hit and sets no interrupt state bit.
- R7: classHit[c] is 1 for exactly the cycle after each cycle in which at least one enabled source mapped to class c fires. Several classes can hit in the same cycle.
- R8: irqState[c] becomes 1 one cycle after a hit to class c. It is cleared by a write with select 4, index c and data bit 0 equal to 1.
- R9: When a cause bit or an interrupt state bit is set by hardware and cleared by software in the same cycle, the bit ends up set.
- R10: The class field is max(1, ceil(log2(NumClasses))) bits wide and is taken from the low bits of the write data. The upper data bits are ignored.
- R11: Configuration writes take effect at the clock edge. An alert that fires in the same cycle as a write is classified with the configuration held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| alertIn | input | NumAlerts | External alert pulses, one per source |
| locAlertIn | input | 7 | Local alert pulses, indexed by local ID |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Operation: 0 lock, 1 enable, 2 class, 3 cause clear, 4 interrupt clear |
| cfgIdx | input | 8 | Source index (or class index for select 4) |
| cfgWdata | input | 8 | Write data |
| causeOut | output | NumAlerts+7 | Sticky cause bits |
| irqState | output | NumClasses | Per-class interrupt state bits |
| classHit | output | NumClasses | Per-class one-cycle hit pulses |
| lockOut | output | NumAlerts+7 | Per-source lock bits |
| enableOut | output | NumAlerts+7 | Per-source enable bits |
| classMapOut | output | (NumAlerts+7)*ClassW | Per-source class fields, source s in bits [s*ClassW +: ClassW] |

## Verification
The hardest case to set up is a set and a clear landing on the same bit in the same cycle, or an alert arriving in the very cycle its configuration is rewritten or locked. Both need the write port and the alert lines lined up to a single edge. The stimulus drives every input of one cycle together and compares all outputs after each edge against a behavioural model. This allows scenarios that fire an alert while clearing its cause or its class interrupt, and scenarios that fire an alert while its enable, class or lock is being written. Frozen fields are exercised by attempting writes after the lock has gone low and then firing the alert to show that the old class is still in use.

// File: rtl/alert_cls_pkg.sv
package alert_cls_pkg;

  localparam int IdxW         = 8;
  localparam int DataW        = 8;
  localparam int NumLocAlerts = 7;

  // Local alert identifiers (offset from NumAlerts in the source index space)
  localparam int LocPingFailAlert = 0;
  localparam int LocPingFailEsc   = 1;
  localparam int LocIntegAlert    = 2;
  localparam int LocIntegEsc      = 3;
  localparam int LocIntegBus      = 4;
  localparam int LocShadowUpdate  = 5;
  localparam int LocShadowStore   = 6;

  typedef enum logic [2:0] {
    SelLock     = 3'd0,
    SelEnable   = 3'd1,
    SelClass    = 3'd2,
    SelCauseClr = 3'd3,
    SelIrqClr   = 3'd4
  } cfgSel_e;

  typedef struct packed {
    logic             lockClr;
    logic             enWr;
    logic             classWr;
    logic             causeClr;
    logic             irqClr;
    logic [IdxW-1:0]  idx;
    logic [DataW-1:0] data;
  } cfgStrb_t;

endpackage

// File: rtl/alert_cls_map.sv
module alert_cls_map
  import alert_cls_pkg::*;
#(
  parameter int NumSrc     = 11,
  parameter int NumClasses = 4,
  parameter int ClassW     = 2
) (
  input  logic [NumSrc-1:0]        fire,
  input  logic [NumSrc-1:0]        enable,
  input  logic [NumSrc*ClassW-1:0] classMap,
  output logic [NumSrc-1:0]        setVec,
  output logic [NumClasses-1:0]    hitVec
);

  assign setVec = fire & enable;

  for (genvar c = 0; c < NumClasses; c++) begin : g_class
    logic [NumSrc-1:0] member;
    for (genvar s = 0; s < NumSrc; s++) begin : g_src
      assign member[s] = (classMap[s*ClassW +: ClassW] == ClassW'(c));
    end
    assign hitVec[c] = |(setVec & member);
  end

endmodule

// File: rtl/alert_cls_ctrl.sv
module alert_cls_ctrl
  import alert_cls_pkg::*;
#(
  parameter int NumSrc     = 11,
  parameter int NumClasses = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [IdxW-1:0]   cfgIdx,
  input  logic [DataW-1:0]  cfgWdata,
  output logic [NumSrc-1:0] lockQ,
  output cfgStrb_t          strb
);

  logic inSrc, inClass, lockAtIdx;
  cfgSel_e sel;

  assign sel     = cfgSel_e'(cfgSel);
  assign inSrc   = (int'(cfgIdx) < NumSrc);
  assign inClass = (int'(cfgIdx) < NumClasses);

  always_comb begin
    lockAtIdx = 1'b0;
    for (int s = 0; s < NumSrc; s++) begin
      if (cfgIdx == IdxW'(s)) lockAtIdx = lockQ[s];
    end
  end

  always_comb begin
    strb          = '0;
    strb.idx      = cfgIdx;
    strb.data     = cfgWdata;
    if (cfgWe) begin
      unique case (sel)
        SelLock:     strb.lockClr  = inSrc && !cfgWdata[0];
        SelEnable:   strb.enWr     = inSrc && lockAtIdx;
        SelClass:    strb.classWr  = inSrc && lockAtIdx;
        SelCauseClr: strb.causeClr = inSrc && cfgWdata[0];
        SelIrqClr:   strb.irqClr   = inClass && cfgWdata[0];
        default:     ;
      endcase
    end
  end

  for (genvar s = 0; s < NumSrc; s++) begin : g_lock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lockQ[s] <= 1'b1;
      end else if (strb.lockClr && strb.idx == IdxW'(s)) begin
        lockQ[s] <= 1'b0;
      end
    end
  end

  // R2: a lock bit never returns to 1 after being cleared
  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ & ~$past(lockQ)) == '0);

  // R4: a single write produces at most one strobe
  assert_single_op_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.lockClr, strb.enWr, strb.classWr, strb.causeClr, strb.irqClr}));

  // R4: no strobe without a write
  assert_no_op_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |-> !(strb.lockClr || strb.enWr || strb.classWr || strb.causeClr || strb.irqClr));

endmodule

// File: rtl/alert_cls_datapath.sv
module alert_cls_datapath
  import alert_cls_pkg::*;
#(
  parameter int NumSrc     = 11,
  parameter int NumClasses = 4,
  parameter int ClassW     = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NumSrc-1:0]        fire,
  input  logic [NumSrc-1:0]        lockQ,
  input  cfgStrb_t                 strb,
  output logic [NumSrc-1:0]        enQ,
  output logic [NumSrc*ClassW-1:0] classQ,
  output logic [NumSrc-1:0]        causeQ,
  output logic [NumClasses-1:0]    irqQ,
  output logic [NumClasses-1:0]    hitQ
);

  logic [NumSrc-1:0]     setVec;
  logic [NumClasses-1:0] hitVec;
  logic                  unusedStrb;

  assign unusedStrb = ^{strb.lockClr, strb.data[DataW-1:ClassW]};

  alert_cls_map #(
    .NumSrc    (NumSrc),
    .NumClasses(NumClasses),
    .ClassW    (ClassW)
  ) u_map (
    .fire    (fire),
    .enable  (enQ),
    .classMap(classQ),
    .setVec  (setVec),
    .hitVec  (hitVec)
  );

  for (genvar s = 0; s < NumSrc; s++) begin : g_src
    logic sel;
    assign sel = (strb.idx == IdxW'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[s]                     <= 1'b0;
        classQ[s*ClassW +: ClassW] <= '0;
        causeQ[s]                  <= 1'b0;
      end else begin
        if (strb.enWr && sel)    enQ[s] <= strb.data[0];
        if (strb.classWr && sel) classQ[s*ClassW +: ClassW] <= strb.data[ClassW-1:0];
        causeQ[s] <= setVec[s] | (causeQ[s] & ~(strb.causeClr && sel));
      end
    end

    // R3: class field frozen while the lock is clear
    assert_class_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
      !$past(lockQ[s]) |-> $stable(classQ[s*ClassW +: ClassW]));
  end

  for (genvar c = 0; c < NumClasses; c++) begin : g_cls
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqQ[c] <= 1'b0;
        hitQ[c] <= 1'b0;
      end else begin
        hitQ[c] <= hitVec[c];
        irqQ[c] <= hitVec[c] | (irqQ[c] & ~(strb.irqClr && strb.idx == IdxW'(c)));
      end
    end
  end

  // R3: enables frozen while the lock is clear
  assert_enable_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((~$past(lockQ)) & (enQ ^ $past(enQ))) == '0);

  // R5: a cause bit only falls after a clear strobe
  assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(causeQ) & ~causeQ)) |-> $past(strb.causeClr));

  // R6: a cause bit only rises for a source that fired while enabled
  assert_cause_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (causeQ & ~$past(causeQ) & ~$past(fire & enQ)) == '0);

  // R9: a hit always leaves its interrupt bit set
  assert_hit_sets_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hitQ & ~irqQ) == '0);

endmodule

// File: rtl/alert_cls_top.sv
module alert_cls_top
  import alert_cls_pkg::*;
#(
  parameter  int NumAlerts  = 4,
  parameter  int NumClasses = 4,
  localparam int NumSrc     = NumAlerts + NumLocAlerts,
  localparam int ClassW     = (NumClasses > 1) ? $clog2(NumClasses) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NumAlerts-1:0]     alertIn,
  input  logic [NumLocAlerts-1:0]  locAlertIn,
  input  logic                     cfgWe,
  input  logic [2:0]               cfgSel,
  input  logic [IdxW-1:0]          cfgIdx,
  input  logic [DataW-1:0]         cfgWdata,
  output logic [NumSrc-1:0]        causeOut,
  output logic [NumClasses-1:0]    irqState,
  output logic [NumClasses-1:0]    classHit,
  output logic [NumSrc-1:0]        lockOut,
  output logic [NumSrc-1:0]        enableOut,
  output logic [NumSrc*ClassW-1:0] classMapOut
);

  cfgStrb_t          strb;
  logic [NumSrc-1:0] fire;

  assign fire = {locAlertIn, alertIn};

  alert_cls_ctrl #(
    .NumSrc    (NumSrc),
    .NumClasses(NumClasses)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .cfgIdx  (cfgIdx),
    .cfgWdata(cfgWdata),
    .lockQ   (lockOut),
    .strb    (strb)
  );

  alert_cls_datapath #(
    .NumSrc    (NumSrc),
    .NumClasses(NumClasses),
    .ClassW    (ClassW)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .fire  (fire),
    .lockQ (lockOut),
    .strb  (strb),
    .enQ   (enableOut),
    .classQ(classMapOut),
    .causeQ(causeOut),
    .irqQ  (irqState),
    .hitQ  (classHit)
  );

endmodule

// File: tb/tb_alert_cls_top.sv
`timescale 1ns/1ps
module tb_alert_cls_top;

  localparam int NA = 4;
  localparam int NC = 4;
  localparam int NL = 7;
  localparam int NS = NA + NL;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NA-1:0] aIn = '0;
  logic [NL-1:0] lIn = '0;
  logic we = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] idx = '0;
  logic [7:0] wd = '0;

  logic [NS-1:0]    causeOut, lockOut, enableOut;
  logic [NC-1:0]    irqState, classHit;
  logic [NS*CW-1:0] classMapOut;

  alert_cls_top #(.NumAlerts(NA), .NumClasses(NC)) dut (
    .clk(clk), .rstN(rstN), .alertIn(aIn), .locAlertIn(lIn),
    .cfgWe(we), .cfgSel(sel), .cfgIdx(idx), .cfgWdata(wd),
    .causeOut(causeOut), .irqState(irqState), .classHit(classHit),
    .lockOut(lockOut), .enableOut(enableOut), .classMapOut(classMapOut)
  );

  always #2.5 clk = ~clk;

  // reference model state
  logic [NS-1:0] mLock, mEn, mCause;
  logic [NC-1:0] mIrq, mHit;
  int            mCls [NS];

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R1";
  bit    done   = 0;

  task automatic modelReset();
    mLock = '1; mEn = '0; mCause = '0; mIrq = '0; mHit = '0;
    for (int s = 0; s < NS; s++) mCls[s] = 0;
  endtask

  task automatic modelStep();
    logic [NS-1:0] f, setV, clrC, nLock, nEn;
    logic [NC-1:0] hitV, clrI;
    int nCls [NS];
    f = {lIn, aIn};
    setV = '0; hitV = '0; clrC = '0; clrI = '0;
    nLock = mLock; nEn = mEn;
    for (int s = 0; s < NS; s++) begin
      nCls[s] = mCls[s];
      if (f[s] && mEn[s]) begin
        setV[s] = 1'b1;
        hitV[mCls[s]] = 1'b1;
      end
    end
    if (we) begin
      case (int'(sel))
        0: if (int'(idx) < NS && !wd[0]) nLock[idx] = 1'b0;
        1: if (int'(idx) < NS && mLock[idx]) nEn[idx] = wd[0];
        2: if (int'(idx) < NS && mLock[idx]) nCls[idx] = int'(wd) % NC;
        3: if (int'(idx) < NS && wd[0]) clrC[idx] = 1'b1;
        4: if (int'(idx) < NC && wd[0]) clrI[idx] = 1'b1;
        default: ;
      endcase
    end
    mCause = (mCause & ~clrC) | setV;
    mIrq   = (mIrq & ~clrI) | hitV;
    mHit   = hitV;
    mLock  = nLock;
    mEn    = nEn;
    for (int s = 0; s < NS; s++) mCls[s] = nCls[s];
  endtask

  task automatic cmp(string name, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, name, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [NS*CW-1:0] expMap;
    for (int s = 0; s < NS; s++) expMap[s*CW +: CW] = CW'(mCls[s]);
    cmp("causeOut",    64'(causeOut),    64'(mCause));
    cmp("irqState",    64'(irqState),    64'(mIrq));
    cmp("classHit",    64'(classHit),    64'(mHit));
    cmp("lockOut",     64'(lockOut),     64'(mLock));
    cmp("enableOut",   64'(enableOut),   64'(mEn));
    cmp("classMapOut", 64'(classMapOut), 64'(expMap));
  endtask

  // apply one cycle of stimulus, advance the model, compare after the edge
  task automatic cyc(input logic w, input int s, input int i, input int d,
                     input logic [NA-1:0] a, input logic [NL-1:0] l);
    we = w; sel = 3'(s); idx = 8'(i); wd = 8'(d); aIn = a; lIn = l;
    modelStep();
    @(posedge clk);
    #1;
    compareAll();
  endtask

  task automatic idle(); cyc(1'b0, 0, 0, 0, '0, '0); endtask
  task automatic wr(int s, int i, int d); cyc(1'b1, s, i, d, '0, '0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    curReq = "R1";
    compareAll();
    idle();

    // enable two external alerts in different classes
    curReq = "R5";
    wr(2, 0, 1); wr(1, 0, 1);
    wr(2, 1, 2); wr(1, 1, 1);
    cyc(1'b0, 0, 0, 0, 4'b0001, '0);   // cause 0, hit class 1
    curReq = "R7";
    idle();                            // hit pulse is gone
    curReq = "R8";
    idle();

    // disabled source fires
    curReq = "R6";
    cyc(1'b0, 0, 0, 0, 4'b0100, '0);
    idle();

    // W1C semantics on causes and interrupts
    curReq = "R5";
    wr(3, 0, 0);
    wr(3, 0, 1);
    curReq = "R8";
    wr(4, 1, 0);
    wr(4, 1, 1);

    // set beats clear in the same cycle
    curReq = "R9";
    cyc(1'b1, 3, 0, 1, 4'b0001, '0);
    cyc(1'b1, 4, 1, 1, 4'b0001, '0);
    wr(3, 0, 1); wr(4, 1, 1);

    // multiple classes in one cycle
    curReq = "R7";
    cyc(1'b0, 0, 0, 0, 4'b0011, '0);
    idle();

    // class field takes the low data bits
    curReq = "R10";
    wr(2, 3, 8'hFD); wr(1, 3, 1);
    cyc(1'b0, 0, 0, 0, 4'b1000, '0);

    // local alerts: bus integrity and shadow storage
    curReq = "R4";
    wr(1, NA + 4, 1); wr(2, NA + 4, 3);
    wr(1, NA + 6, 1); wr(2, NA + 6, 2);
    cyc(1'b0, 0, 0, 0, '0, 7'b0010000);
    cyc(1'b0, 0, 0, 0, '0, 7'b1000000);
    cyc(1'b0, 0, 0, 0, '0, 7'b0000001);  // ping-failure local alert is disabled
    // unknown select and out-of-range indexes
    wr(7, 2, 1); wr(5, 2, 1); wr(1, NS, 1); wr(2, 200, 3); wr(0, NS, 0);
    wr(4, NC, 1); wr(3, NS + 3, 1);
    cyc(1'b0, 0, 0, 0, 4'b0100, '0);

    // config write in the same cycle as the alert
    curReq = "R11";
    cyc(1'b1, 2, 0, 3, 4'b0001, '0);    // uses old class 1
    cyc(1'b0, 0, 0, 0, 4'b0001, '0);    // uses new class 3
    cyc(1'b1, 1, 2, 1, 4'b0100, '0);    // still disabled this cycle
    cyc(1'b0, 0, 0, 0, 4'b0100, '0);

    // locking
    curReq = "R2";
    wr(0, 0, 1);                        // writing 1 leaves the lock set
    wr(0, 0, 0);
    wr(0, 0, 1);
    curReq = "R3";
    wr(1, 0, 0); wr(2, 0, 0);
    cyc(1'b0, 0, 0, 0, 4'b0001, '0);    // still enabled, still class 3
    wr(0, NA + 4, 0);
    wr(1, NA + 4, 0); wr(2, NA + 4, 1);
    cyc(1'b0, 0, 0, 0, '0, 7'b0010000);
    // clear and re-check every cause and interrupt
    curReq = "R5";
    for (int s = 0; s < NS; s++) wr(3, s, 1);
    curReq = "R8";
    for (int c = 0; c < NC; c++) wr(4, c, 1);
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule